// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Error Flags

This block turns a serial receive line into bytes held in a single receive holding register. A three-bit frame selector picks the character layout (seven or eight data bits, even, odd or no parity, one or two stop bits). A two-bit ratio selector picks how many sample-clock ticks make one bit time. The same ratio selector, when both bits are high, holds the whole receiver in master reset. The line is idle high, and data bits arrive least significant first.

With an oversampling ratio, a falling edge starts a candidate character. The receiver confirms the start bit by sampling it low again half a bit later, then samples every following bit at its centre. With a ratio of one, each tick is one bit time and there is no confirmation. When the first stop bit has been sampled, the character is complete. If the holding register is empty, the byte goes into it together with its own parity and framing status. If the register is still full, the new character is dropped and an overrun is flagged. A one-cycle read strobe empties the register and clears every flag that belongs to the character.

Top module: `serial_rx_core`

## Requirements
- R1: After the asynchronous reset, `rx_full`, `overrun`, `parity_err` and `framing_err` are 0 and `rx_data` is 0x00.
- R2: With frame code 3'b101 (eight data bits, no parity) or 3'b100 (eight data bits, no parity, second stop bit ignored), a character sent least significant bit first appears unchanged on `rx_data`, and `rx_full` rises once the first stop bit has been sampled.
- R3: Frame codes with bit 2 clear carry seven data bits. `rx_data[7]` then reads 0 and bits 6:0 hold the character.
- R4: Frame code bit 0 selects odd parity (1) or even parity (0) for codes 3'b000, 3'b001, 3'b010, 3'b011, 3'b110 and 3'b111. `parity_err` is 1 exactly when the received parity bit disagrees with that rule.
- R5: With frame codes 3'b100 and 3'b101, no parity bit is expected and `parity_err` stays 0.
- R6: A first stop bit sampled low sets `framing_err` for that character. A stop bit sampled high leaves it 0.
- R7: A character that completes while `rx_full` is 1 and no read happens in that cycle is lost. `overrun` sets, and `rx_data`, `parity_err` and `framing_err` keep the values of the earlier character.
- R8: A cycle with `rd_strobe` high clears `rx_full`, `overrun`, `parity_err` and `framing_err`.
- R9: While `div_sel` is 2'b11 (master reset), all four flags are held at 0 and no reception takes place.
- R10: With an oversampling ratio, a low pulse on `rx_line` shorter than half a bit time is rejected at the start-bit midpoint check and produces no character.
- R11: `div_sel` 2'b00, 2'b01 and 2'b10 select 1, `DIV_LO` (16) and `DIV_HI` (64) ticks per bit, and characters are received correctly at each ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| sample_tick | input | 1 | Sample-clock enable, one pulse per tick |
| word_sel | input | 3 | Frame layout code |
| div_sel | input | 2 | Ticks-per-bit select; 2'b11 is master reset |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Holding register holds an unread character |
| parity_err | output | 1 | Parity error of the held character |
| framing_err | output | 1 | Stop-bit error of the held character |
| overrun | output | 1 | A character was lost while the register was full |

## Verification
A bit-timing error in the sampling engine (off-centre sampling, a wrong ratio, a missed start confirmation) shows up at the ports as a wrong byte or a wrong parity or framing flag. It becomes visible one cycle after the stop-bit sample of the affected character. An error in the holding logic shows as a flag that survives a read or master reset, or as a byte overwritten during an overrun. Both show on the cycle after the strobe or the character completion. The bench therefore compares every port against a model built from the frame rules after each character and after each strobe.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_odd;
  } rx_frame_t;

  localparam logic [1:0] DIV_MRESET = 2'b11;

endpackage

// File: rtl/serial_rx_frame_dec.sv
module serial_rx_frame_dec
  import serial_rx_pkg::*;
(
  input  logic [2:0] word_sel,
  output rx_frame_t  frame
);

  always_comb begin
    frame.nbits   = word_sel[2] ? 4'd8 : 4'd7;
    frame.par_en  = !(word_sel[2] && !word_sel[1]);
    frame.par_odd = word_sel[0];
  end

endmodule

// File: rtl/serial_rx_shifter.sv
module serial_rx_shifter
  import serial_rx_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 64,
  localparam int CW = $clog2(DIV_HI)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] div_sel,
  input  rx_frame_t  frame,
  output logic       done,
  output logic [7:0] data_o,
  output logic       par_bad,
  output logic       stop_bad
);

  localparam logic [CW-1:0] LO_M1   = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] HI_M1   = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] LO_HALF = CW'(DIV_LO / 2 - 1);
  localparam logic [CW-1:0] HI_HALF = CW'(DIV_HI / 2 - 1);

  rx_state_t     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [3:0]    idx_q, idx_n;
  logic [7:0]    dat_q, dat_n;
  logic          pacc_q, pacc_n;
  logic          done_q, done_n;
  logic          pbad_q, pbad_n;
  logic          sbad_q, sbad_n;
  logic [CW-1:0] ratio_m1, half_m1;
  logic          div_one;

  always_comb begin
    div_one  = (div_sel == 2'b00);
    ratio_m1 = (div_sel == 2'b10) ? HI_M1 : (div_sel == 2'b01) ? LO_M1 : '0;
    half_m1  = (div_sel == 2'b10) ? HI_HALF : LO_HALF;
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    dat_n  = dat_q;
    pacc_n = pacc_q;
    pbad_n = pbad_q;
    sbad_n = sbad_q;
    done_n = 1'b0;
    if (clr) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
      idx_n = '0;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rx) begin
            cnt_n = '0;
            if (div_one) begin
              st_n   = RX_BITS;
              idx_n  = '0;
              dat_n  = '0;
              pacc_n = 1'b0;
            end else begin
              st_n = RX_START;
            end
          end
        end
        RX_START: begin
          if (cnt_q == half_m1) begin
            cnt_n = '0;
            if (!rx) begin
              st_n   = RX_BITS;
              idx_n  = '0;
              dat_n  = '0;
              pacc_n = 1'b0;
            end else begin
              st_n = RX_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == ratio_m1) begin
            cnt_n = '0;
            if (idx_q < frame.nbits) begin
              dat_n[idx_q[2:0]] = rx;
              pacc_n = pacc_q ^ rx;
              idx_n  = idx_q + 1'b1;
            end else if (frame.par_en && (idx_q == frame.nbits)) begin
              pacc_n = pacc_q ^ rx;
              idx_n  = idx_q + 1'b1;
            end else begin
              done_n = 1'b1;
              sbad_n = !rx;
              pbad_n = frame.par_en && (pacc_q ^ frame.par_odd);
              st_n   = RX_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      pacc_q <= 1'b0;
      done_q <= 1'b0;
      pbad_q <= 1'b0;
      sbad_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      dat_q  <= dat_n;
      pacc_q <= pacc_n;
      done_q <= done_n;
      pbad_q <= pbad_n;
      sbad_q <= sbad_n;
    end
  end

  assign done     = done_q;
  assign data_o   = dat_q;
  assign par_bad  = pbad_q;
  assign stop_bad = sbad_q;

endmodule

// File: rtl/serial_rx_holdreg.sv
module serial_rx_holdreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          done,
  input  logic [DW-1:0] new_data,
  input  logic          new_pbad,
  input  logic          new_sbad,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          pe,
  output logic          fe,
  output logic          ovr
);

  logic [DW-1:0] data_n;
  logic          full_n, pe_n, fe_n, ovr_n;
  logic          load_en;

  always_comb begin
    data_n  = data;
    full_n  = full;
    pe_n    = pe;
    fe_n    = fe;
    ovr_n   = ovr;
    load_en = done && (!full || rd);
    if (clr) begin
      full_n = 1'b0;
      pe_n   = 1'b0;
      fe_n   = 1'b0;
      ovr_n  = 1'b0;
    end else begin
      if (rd) begin
        full_n = 1'b0;
        pe_n   = 1'b0;
        fe_n   = 1'b0;
        ovr_n  = 1'b0;
      end
      if (load_en) begin
        data_n = new_data;
        full_n = 1'b1;
        pe_n   = new_pbad;
        fe_n   = new_sbad;
      end else if (done) begin
        ovr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      pe   <= 1'b0;
      fe   <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      data <= data_n;
      full <= full_n;
      pe   <= pe_n;
      fe   <= fe_n;
      ovr  <= ovr_n;
    end
  end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       sample_tick,
  input  logic [2:0] word_sel,
  input  logic [1:0] div_sel,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       parity_err,
  output logic       framing_err,
  output logic       overrun
);

  rx_frame_t  frame;
  logic       mreset;
  logic       chr_done;
  logic [7:0] chr_data;
  logic       chr_pbad, chr_sbad;

  assign mreset = (div_sel == DIV_MRESET);

  serial_rx_frame_dec u_dec (
    .word_sel (word_sel),
    .frame    (frame)
  );

  serial_rx_shifter #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mreset),
    .tick     (sample_tick),
    .rx       (rx_line),
    .div_sel  (div_sel),
    .frame    (frame),
    .done     (chr_done),
    .data_o   (chr_data),
    .par_bad  (chr_pbad),
    .stop_bad (chr_sbad)
  );

  serial_rx_holdreg #(.DW(8)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mreset),
    .done     (chr_done),
    .new_data (chr_data),
    .new_pbad (chr_pbad),
    .new_sbad (chr_sbad),
    .rd       (rd_strobe),
    .data     (rx_data),
    .full     (rx_full),
    .pe       (parity_err),
    .fe       (framing_err),
    .ovr      (overrun)
  );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] div_sel,
  input logic [2:0] word_sel,
  input logic       rd_strobe,
  input logic       done,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       parity_err,
  input logic       framing_err,
  input logic       overrun
);

  logic mres;
  assign mres = (div_sel == 2'b11);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!rx_full || rd_strobe) && !mres) |=> rx_full);

  p_bit7_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!rx_full || rd_strobe) && !mres && !word_sel[2]) |=> !rx_data[7]);

  p_nopar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!rx_full || rd_strobe) && !mres && word_sel[2:1] == 2'b10) |=> !parity_err);

  p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_strobe && !mres) |=> (overrun && $stable(rx_data)));

  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done && !mres) |=> (!rx_full && !overrun && !parity_err && !framing_err));

  p_mreset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mres |=> (!rx_full && !overrun && !parity_err && !framing_err));

endmodule

bind serial_rx_core serial_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .div_sel     (div_sel),
  .word_sel    (word_sel),
  .rd_strobe   (rd_strobe),
  .done        (chr_done),
  .rx_data     (rx_data),
  .rx_full     (rx_full),
  .parity_err  (parity_err),
  .framing_err (framing_err),
  .overrun     (overrun)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       sample_tick = 1'b1;
  logic [2:0] word_sel = 3'b101;
  logic [1:0] div_sel = 2'b01;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, parity_err, framing_err, overrun;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .sample_tick(sample_tick),
    .word_sel(word_sel), .div_sel(div_sel), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .parity_err(parity_err),
    .framing_err(framing_err), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
  endfunction

  task automatic hold_line(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  // Sends one character; returns after stop bit and a short idle gap.
  task automatic send(input logic [7:0] b, input logic flip_par, input logic stop_v);
    int n, nb;
    logic pen, podd, p;
    n    = ratio_of(div_sel);
    nb   = word_sel[2] ? 8 : 7;
    pen  = !(word_sel[2] && !word_sel[1]);
    podd = word_sel[0];
    p    = 1'b0;
    hold_line(1'b0, n);
    for (int i = 0; i < nb; i++) begin
      p ^= b[i];
      hold_line(b[i], n);
    end
    if (pen) hold_line(p ^ podd ^ flip_par, n);
    hold_line(stop_v, n);
    hold_line(1'b1, 2 * n + 2);
  endtask

  task automatic read_reg();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 full", rx_full, 0);
    chk("R1 ovr", overrun, 0);
    chk("R1 pe", parity_err, 0);
    chk("R1 fe", framing_err, 0);
    chk("R1 data", rx_data, 0);
  endtask

  task automatic t_eight_bit();
    word_sel = 3'b101; div_sel = 2'b01;
    send(8'hA5, 1'b0, 1'b1);
    chk("R2 full", rx_full, 1);
    chk("R2 data", rx_data, 8'hA5);
    chk("R5 pe 8N1", parity_err, 0);
    chk("R6 fe clear", framing_err, 0);
    read_reg();
    chk("R8 full cleared", rx_full, 0);
    word_sel = 3'b100;
    send(8'h3C, 1'b0, 1'b1);
    chk("R2 data 8N2", rx_data, 8'h3C);
    chk("R5 pe 8N2", parity_err, 0);
    read_reg();
  endtask

  task automatic t_seven_bit();
    word_sel = 3'b010; div_sel = 2'b01;
    send(8'hFF, 1'b0, 1'b1);
    chk("R3 data 7E1", rx_data, 8'h7F);
    chk("R4 pe even ok", parity_err, 0);
    read_reg();
    word_sel = 3'b001;
    send(8'h96, 1'b1, 1'b1);
    chk("R3 data 7O2", rx_data, 8'h16);
    chk("R4 pe odd bad", parity_err, 1);
    read_reg();
    chk("R8 pe cleared", parity_err, 0);
  endtask

  task automatic t_eight_parity();
    word_sel = 3'b111; div_sel = 2'b01;
    send(8'h81, 1'b0, 1'b1);
    chk("R4 data 8O1", rx_data, 8'h81);
    chk("R4 pe odd ok", parity_err, 0);
    read_reg();
    word_sel = 3'b110;
    send(8'h07, 1'b1, 1'b1);
    chk("R4 pe even bad", parity_err, 1);
    read_reg();
  endtask

  task automatic t_framing();
    word_sel = 3'b101; div_sel = 2'b01;
    send(8'h5A, 1'b0, 1'b0);
    chk("R6 fe set", framing_err, 1);
    chk("R6 data", rx_data, 8'h5A);
    read_reg();
    chk("R8 fe cleared", framing_err, 0);
  endtask

  task automatic t_overrun();
    word_sel = 3'b010; div_sel = 2'b01;
    send(8'h11, 1'b1, 1'b1);
    chk("R7 first pe", parity_err, 1);
    send(8'h22, 1'b0, 1'b1);
    chk("R7 ovr set", overrun, 1);
    chk("R7 data kept", rx_data, 8'h11);
    chk("R7 pe kept", parity_err, 1);
    chk("R7 full", rx_full, 1);
    read_reg();
    chk("R8 ovr cleared", overrun, 0);
    chk("R8 full cleared", rx_full, 0);
  endtask

  task automatic t_mreset();
    word_sel = 3'b101; div_sel = 2'b01;
    send(8'hC3, 1'b0, 1'b0);
    div_sel = 2'b11;
    repeat (3) @(negedge clk);
    chk("R9 full", rx_full, 0);
    chk("R9 fe", framing_err, 0);
    hold_line(1'b0, 40);
    hold_line(1'b1, 40);
    chk("R9 no rx", rx_full, 0);
    div_sel = 2'b01;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_glitch();
    word_sel = 3'b101; div_sel = 2'b01;
    hold_line(1'b0, 5);
    hold_line(1'b1, 60);
    chk("R10 glitch ignored", rx_full, 0);
    send(8'h69, 1'b0, 1'b1);
    chk("R10 after glitch", rx_data, 8'h69);
    read_reg();
  endtask

  task automatic t_ratios();
    word_sel = 3'b101; div_sel = 2'b00;
    send(8'hB7, 1'b0, 1'b1);
    chk("R11 div1 data", rx_data, 8'hB7);
    chk("R11 div1 full", rx_full, 1);
    read_reg();
    div_sel = 2'b10; word_sel = 3'b011;
    send(8'h4E, 1'b0, 1'b1);
    chk("R11 div64 data", rx_data, 8'h4E);
    chk("R11 div64 pe", parity_err, 0);
    read_reg();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_eight_bit();
    t_seven_bit();
    t_eight_parity();
    t_framing();
    t_overrun();
    t_mreset();
    t_glitch();
    t_ratios();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule